// File: doc/BRIEF.md
# SDRAM Single-Access Command Sequencer

This block sits between a simple host request port and an SDRAM device. It takes one 32-bit read or write at a time and turns it into a fixed command template: activate the row, wait, issue a column command with auto-precharge, then wait until the bank has closed again. Every access is a single beat. A transfer wider than the data bus is built by the host, which issues several single accesses back to back.

The host address is split into bank, row and column fields. These are driven on the SDRAM address and bank pins in the row phase and in the column phase. Four 2-bit configuration fields set the wait counts: activate to command, CAS latency, write recovery and precharge completion. Read data is captured from the bus, and the host sees a one-cycle completion pulse. A refresh hook lets an external refresh engine claim the idle sequencer ahead of the host. The sequencer never interrupts an access that has already started.

Top module: `sdr_access_seq`

## Requirements
- R1: While reset is high, and in the first cycle after it, chip select is high (deselect), dq_oe is 0, all byte masks are 1, and done, req_ack and ref_gnt are 0.
- R2: A read accepted at cycle edge E drives the following commands, counting from the cycle after E as index 0:
  - ACTV at index 0.
  - Deselect for the activate-to-command wait count.
  - READA.
  - Deselect for (CAS latency − 1) cycles.
  - One capture cycle, in which sd_dq_in is sampled at its closing edge.
  - One idle cycle.
  - Deselect for the precharge-completion count.
  - The sequencer is idle again at index 4 + tRCD + (CL−1) + tRP.
- R3: A write drives the following, counting from index 0:
  - ACTV at index 0.
  - Deselect for the activate-to-command wait count.
  - WRITA.
  - Deselect for the write-recovery count.
  - Deselect for the precharge-completion count.
  - The sequencer is idle again at index 2 + tRCD + tWR + tRP.
- R4: The wait-field encodings are:
  - cfg_rcd, cfg_wrec and cfg_pre each give a number of wait cycles equal to their value (0 to 3). Zero inserts no cycle.
  - cfg_cas gives a CAS latency of value + 1.
  - For example, 2'b10 gives 2 cycles and cfg_cas = 2'b01 gives latency 2.
- R5: Commands are encoded on {cs_n, ras_n, cas_n, we_n} as:
  - ACTV = 0011
  - READA = 0101
  - WRITA = 0100
  - Deselect has cs_n = 1.

  In the ACTV cycle, sd_a[12:0] carries req_addr[23:11] and sd_ba carries req_addr[25:24].
- R6: In the READA/WRITA cycle:
  - sd_a[8:0] carries req_addr[10:2].
  - sd_a[10] is 1, requesting auto-precharge.
  - sd_a[9], sd_a[12] and sd_a[11] are 0.
  - sd_ba carries req_addr[25:24].
- R7: Masks (1 = lane masked) are all 1 in every cycle of a read and in every cycle that is not a WRITA. In the WRITA cycle, sd_dqm equals the inverse of the request byte enables (bit n covers data bits 8n+7..8n).
- R8: sd_dq_oe is 1 only in the WRITA cycle. In that cycle sd_dq_out equals the accepted write data.
- R9: done is a one-cycle pulse in the cycle after the capture cycle (read) or the cycle after WRITA (write). For a read, rd_data holds the captured word in that cycle.
- R10: A request is accepted only in the idle state:
  - req_ack is high in the same cycle as req, and ACTV follows in the next cycle.
  - Request inputs that change while an access runs have no effect on that access.
- R11: While idle, a high ref_req raises ref_gnt in the same cycle and blocks acceptance of a simultaneous host request. ref_gnt is never high outside the idle state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_rcd | input | 2 | Activate-to-command wait code |
| cfg_cas | input | 2 | CAS latency code (latency = code + 1) |
| cfg_wrec | input | 2 | Write-recovery wait code |
| cfg_pre | input | 2 | Precharge-completion wait code |
| req | input | 1 | Host access request, held until req_ack |
| req_we | input | 1 | 1 = write, 0 = read |
| req_addr | input | 26 | Host byte address |
| req_wdata | input | 32 | Write data |
| req_be | input | 4 | Byte enables for writes |
| req_ack | output | 1 | Request accepted this cycle |
| done | output | 1 | Access complete pulse |
| rd_data | output | 32 | Captured read data |
| ref_req | input | 1 | Refresh engine requests the idle bus |
| ref_gnt | output | 1 | Refresh granted (sequencer idle) |
| sd_cs_n | output | 1 | SDRAM chip select, active low |
| sd_ras_n | output | 1 | Row strobe, active low |
| sd_cas_n | output | 1 | Column strobe, active low |
| sd_we_n | output | 1 | Write enable, active low |
| sd_a | output | 13 | Multiplexed SDRAM address |
| sd_ba | output | 2 | Bank address |
| sd_dqm | output | 4 | Byte-lane masks |
| sd_dq_out | output | 32 | Data driven toward the SDRAM |
| sd_dq_oe | output | 1 | Output enable for sd_dq_out |
| sd_dq_in | input | 32 | Data returned by the SDRAM |

## Verification
The two functions that can meet in one cycle are host acceptance and refresh grant. Both are decided in the idle state from req and ref_req. The bench raises both together for several idle cycles and expects ref_gnt high, req_ack low and chip select inactive. It then drops ref_req and expects the held request to be taken at once. It also keeps ref_req and a changed request high through a whole access and expects the grant to appear exactly in the first idle cycle, with no acceptance in between.

// File: rtl/sdr_seq_pkg.sv
package sdr_seq_pkg;

    // width of every programmable wait field
    localparam int WF_W = 2;

    typedef logic [WF_W-1:0] wfield_t;

    typedef struct packed {
        wfield_t rcd;   // activate to column command
        wfield_t cas;   // latency minus one
        wfield_t wrec;  // write recovery before precharge
        wfield_t pre;   // precharge completion
    } seq_cfg_t;

    typedef enum logic [3:0] {
        S_IDLE,
        S_ACT,
        S_RCD,
        S_CMD,
        S_CASW,
        S_CAPT,
        S_GAP,
        S_WREC,
        S_PRE
    } seq_state_t;

    typedef struct packed {
        logic cs_n;
        logic ras_n;
        logic cas_n;
        logic we_n;
    } sdr_cmd_t;

    localparam sdr_cmd_t CMD_DESL = '{cs_n: 1'b1, ras_n: 1'b1, cas_n: 1'b1, we_n: 1'b1};
    localparam sdr_cmd_t CMD_ACTV = '{cs_n: 1'b0, ras_n: 1'b0, cas_n: 1'b1, we_n: 1'b1};
    localparam sdr_cmd_t CMD_RDAP = '{cs_n: 1'b0, ras_n: 1'b1, cas_n: 1'b0, we_n: 1'b1};
    localparam sdr_cmd_t CMD_WRAP = '{cs_n: 1'b0, ras_n: 1'b1, cas_n: 1'b0, we_n: 1'b0};

    // activate-to-command: code is the cycle count
    function automatic wfield_t rcd_waits(input wfield_t code);
        return code;
    endfunction

    // CAS latency is code+1, the command itself covers one cycle
    function automatic wfield_t cas_waits(input wfield_t code);
        return code;
    endfunction

    function automatic wfield_t wrec_waits(input wfield_t code);
        return code;
    endfunction

    function automatic wfield_t pre_waits(input wfield_t code);
        return code;
    endfunction

endpackage

// File: rtl/sdr_seq_ctrl.sv
module sdr_seq_ctrl
    import sdr_seq_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       req,
    input  logic       req_we,
    input  logic       ref_req,
    input  seq_cfg_t   cfg,
    output seq_state_t state,
    output logic       op_we,
    output logic       req_ack,
    output logic       ref_gnt,
    output logic       done,
    output logic       cap_en
);

    seq_state_t st_q, st_d;
    wfield_t    cnt_q, cnt_d;
    logic       we_q, we_d;
    logic       done_q;
    logic       take;

    wfield_t n_rcd, n_cas, n_wr, n_pre;

    assign n_rcd = rcd_waits(cfg.rcd);
    assign n_cas = cas_waits(cfg.cas);
    assign n_wr  = wrec_waits(cfg.wrec);
    assign n_pre = pre_waits(cfg.pre);

    // refresh wins over a host request arriving in the same idle cycle
    assign take    = (st_q == S_IDLE) && req && !ref_req;
    assign req_ack = take;
    assign ref_gnt = (st_q == S_IDLE) && ref_req;

    always_comb begin
        st_d  = st_q;
        cnt_d = cnt_q;
        we_d  = we_q;
        case (st_q)
            S_IDLE: begin
                if (take) begin
                    st_d = S_ACT;
                    we_d = req_we;
                end
            end
            S_ACT: begin
                if (n_rcd != '0) begin
                    st_d  = S_RCD;
                    cnt_d = n_rcd;
                end else begin
                    st_d = S_CMD;
                end
            end
            S_RCD: begin
                if (cnt_q == wfield_t'(1)) st_d = S_CMD;
                else                       cnt_d = cnt_q - wfield_t'(1);
            end
            S_CMD: begin
                if (we_q) begin
                    if (n_wr != '0) begin
                        st_d  = S_WREC;
                        cnt_d = n_wr;
                    end else if (n_pre != '0) begin
                        st_d  = S_PRE;
                        cnt_d = n_pre;
                    end else begin
                        st_d = S_IDLE;
                    end
                end else if (n_cas != '0) begin
                    st_d  = S_CASW;
                    cnt_d = n_cas;
                end else begin
                    st_d = S_CAPT;
                end
            end
            S_CASW: begin
                if (cnt_q == wfield_t'(1)) st_d = S_CAPT;
                else                       cnt_d = cnt_q - wfield_t'(1);
            end
            S_CAPT: st_d = S_GAP;
            S_GAP: begin
                if (n_pre != '0) begin
                    st_d  = S_PRE;
                    cnt_d = n_pre;
                end else begin
                    st_d = S_IDLE;
                end
            end
            S_WREC: begin
                if (cnt_q != wfield_t'(1)) begin
                    cnt_d = cnt_q - wfield_t'(1);
                end else if (n_pre != '0) begin
                    st_d  = S_PRE;
                    cnt_d = n_pre;
                end else begin
                    st_d = S_IDLE;
                end
            end
            S_PRE: begin
                if (cnt_q == wfield_t'(1)) st_d = S_IDLE;
                else                       cnt_d = cnt_q - wfield_t'(1);
            end
            default: st_d = S_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q   <= S_IDLE;
            cnt_q  <= '0;
            we_q   <= 1'b0;
            done_q <= 1'b0;
        end else begin
            st_q   <= st_d;
            cnt_q  <= cnt_d;
            we_q   <= we_d;
            done_q <= (st_q == S_CAPT) || ((st_q == S_CMD) && we_q);
        end
    end

    assign state  = st_q;
    assign op_we  = we_q;
    assign done   = done_q;
    assign cap_en = (st_q == S_CAPT);

endmodule

// File: rtl/sdr_addr_map.sv
module sdr_addr_map #(
    parameter int ADDR_W  = 26,
    parameter int ROW_W   = 13,
    parameter int COL_W   = 9,
    parameter int BANK_W  = 2,
    parameter int SA_W    = 13,
    parameter int AP_BIT  = 10,
    parameter int BYTE_SH = 2
) (
    input  logic [ADDR_W-1:0] addr,
    output logic [SA_W-1:0]   row_sa,
    output logic [SA_W-1:0]   col_sa,
    output logic [BANK_W-1:0] bank
);

    localparam int COL_LO  = BYTE_SH;
    localparam int ROW_LO  = COL_LO + COL_W;
    localparam int BANK_LO = ROW_LO + ROW_W;

    assign bank = addr[BANK_LO +: BANK_W];

    for (genvar i = 0; i < SA_W; i++) begin : g_pin
        // row phase: straight mapping, unused upper pins low
        if (i < ROW_W) begin : g_row
            assign row_sa[i] = addr[ROW_LO + i];
        end else begin : g_row_pad
            assign row_sa[i] = 1'b0;
        end

        // column phase: the precharge pin is skipped and held high
        if (i == AP_BIT) begin : g_ap
            assign col_sa[i] = 1'b1;
        end else if ((i < AP_BIT) && (i < COL_W)) begin : g_col_lo
            assign col_sa[i] = addr[COL_LO + i];
        end else if ((i > AP_BIT) && (i - 1 < COL_W)) begin : g_col_hi
            assign col_sa[i] = addr[COL_LO + i - 1];
        end else begin : g_col_pad
            assign col_sa[i] = 1'b0;
        end
    end

endmodule

// File: rtl/sdr_pin_drive.sv
module sdr_pin_drive
    import sdr_seq_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int BE_W   = 4,
    parameter int SA_W   = 13
) (
    input  seq_state_t        state,
    input  logic              op_we,
    input  logic [SA_W-1:0]   row_sa,
    input  logic [SA_W-1:0]   col_sa,
    input  logic [BE_W-1:0]   be,
    input  logic [DATA_W-1:0] wdata,
    output sdr_cmd_t          cmd,
    output logic [SA_W-1:0]   sa,
    output logic [BE_W-1:0]   dqm,
    output logic [DATA_W-1:0] dq_out,
    output logic              dq_oe
);

    logic in_act, in_cmd, wr_beat;

    assign in_act  = (state == S_ACT);
    assign in_cmd  = (state == S_CMD);
    assign wr_beat = in_cmd && op_we;

    always_comb begin
        cmd = CMD_DESL;
        sa  = '0;
        if (in_act) begin
            cmd = CMD_ACTV;
            sa  = row_sa;
        end else if (in_cmd) begin
            cmd = op_we ? CMD_WRAP : CMD_RDAP;
            sa  = col_sa;
        end
    end

    assign dqm    = wr_beat ? ~be : '1;
    assign dq_oe  = wr_beat;
    assign dq_out = wdata;

endmodule

// File: rtl/sdr_access_seq.sv
module sdr_access_seq
    import sdr_seq_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 26,
    parameter int ROW_W  = 13,
    parameter int COL_W  = 9,
    parameter int BANK_W = 2,
    parameter int SA_W   = 13,
    parameter int AP_BIT = 10
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic [WF_W-1:0]       cfg_rcd,
    input  logic [WF_W-1:0]       cfg_cas,
    input  logic [WF_W-1:0]       cfg_wrec,
    input  logic [WF_W-1:0]       cfg_pre,
    input  logic                  req,
    input  logic                  req_we,
    input  logic [ADDR_W-1:0]     req_addr,
    input  logic [DATA_W-1:0]     req_wdata,
    input  logic [DATA_W/8-1:0]   req_be,
    output logic                  req_ack,
    output logic                  done,
    output logic [DATA_W-1:0]     rd_data,
    input  logic                  ref_req,
    output logic                  ref_gnt,
    output logic                  sd_cs_n,
    output logic                  sd_ras_n,
    output logic                  sd_cas_n,
    output logic                  sd_we_n,
    output logic [SA_W-1:0]       sd_a,
    output logic [BANK_W-1:0]     sd_ba,
    output logic [DATA_W/8-1:0]   sd_dqm,
    output logic [DATA_W-1:0]     sd_dq_out,
    output logic                  sd_dq_oe,
    input  logic [DATA_W-1:0]     sd_dq_in
);

    localparam int BE_W    = DATA_W / 8;
    localparam int BYTE_SH = $clog2(BE_W);

    seq_cfg_t   cfg;
    seq_state_t state;
    logic       op_we, cap_en;
    sdr_cmd_t   cmd;

    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] wdata_q;
    logic [BE_W-1:0]   be_q;
    logic [DATA_W-1:0] rdat_q;
    logic [SA_W-1:0]   row_sa, col_sa;

    assign cfg = '{rcd: cfg_rcd, cas: cfg_cas, wrec: cfg_wrec, pre: cfg_pre};

    sdr_seq_ctrl u_ctrl (
        .clk     (clk),
        .rst     (rst),
        .req     (req),
        .req_we  (req_we),
        .ref_req (ref_req),
        .cfg     (cfg),
        .state   (state),
        .op_we   (op_we),
        .req_ack (req_ack),
        .ref_gnt (ref_gnt),
        .done    (done),
        .cap_en  (cap_en)
    );

    // request fields are held from acceptance to the end of the access
    always_ff @(posedge clk) begin
        if (rst) begin
            addr_q  <= '0;
            wdata_q <= '0;
            be_q    <= '0;
            rdat_q  <= '0;
        end else begin
            if (req_ack) begin
                addr_q  <= req_addr;
                wdata_q <= req_wdata;
                be_q    <= req_be;
            end
            if (cap_en) rdat_q <= sd_dq_in;
        end
    end

    sdr_addr_map #(
        .ADDR_W  (ADDR_W),
        .ROW_W   (ROW_W),
        .COL_W   (COL_W),
        .BANK_W  (BANK_W),
        .SA_W    (SA_W),
        .AP_BIT  (AP_BIT),
        .BYTE_SH (BYTE_SH)
    ) u_map (
        .addr   (addr_q),
        .row_sa (row_sa),
        .col_sa (col_sa),
        .bank   (sd_ba)
    );

    sdr_pin_drive #(
        .DATA_W (DATA_W),
        .BE_W   (BE_W),
        .SA_W   (SA_W)
    ) u_drv (
        .state  (state),
        .op_we  (op_we),
        .row_sa (row_sa),
        .col_sa (col_sa),
        .be     (be_q),
        .wdata  (wdata_q),
        .cmd    (cmd),
        .sa     (sd_a),
        .dqm    (sd_dqm),
        .dq_out (sd_dq_out),
        .dq_oe  (sd_dq_oe)
    );

    assign sd_cs_n  = cmd.cs_n;
    assign sd_ras_n = cmd.ras_n;
    assign sd_cas_n = cmd.cas_n;
    assign sd_we_n  = cmd.we_n;
    assign rd_data  = rdat_q;

endmodule

// File: rtl/sdr_access_seq_chk.sv
module sdr_access_seq_chk #(
    parameter int SA_W   = 13,
    parameter int BE_W   = 4,
    parameter int AP_BIT = 10
) (
    input logic            clk,
    input logic            rst,
    input logic            req_ack,
    input logic            ref_req,
    input logic            ref_gnt,
    input logic            done,
    input logic            sd_cs_n,
    input logic            sd_ras_n,
    input logic            sd_cas_n,
    input logic            sd_we_n,
    input logic [SA_W-1:0] sd_a,
    input logic [BE_W-1:0] sd_dqm,
    input logic            sd_dq_oe
);

    logic col_cmd;
    assign col_cmd = !sd_cs_n && sd_ras_n && !sd_cas_n;

    // R1
    reset_quiet_chk: assert property (@(posedge clk)
        rst |=> (sd_cs_n && !sd_dq_oe && !done));

    // R2
    col_then_desl_chk: assert property (@(posedge clk) disable iff (rst)
        col_cmd |=> sd_cs_n);

    // R6
    autopre_bit_chk: assert property (@(posedge clk) disable iff (rst)
        col_cmd |-> sd_a[AP_BIT]);

    // R7
    read_masked_chk: assert property (@(posedge clk) disable iff (rst)
        (col_cmd && sd_we_n) |-> (&sd_dqm));

    // R8
    drive_on_write_chk: assert property (@(posedge clk) disable iff (rst)
        sd_dq_oe |-> (col_cmd && !sd_we_n));

    // R9
    done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R10
    ack_then_act_chk: assert property (@(posedge clk) disable iff (rst)
        req_ack |=> (!sd_cs_n && !sd_ras_n && sd_cas_n && sd_we_n));

    // R11
    refresh_wins_chk: assert property (@(posedge clk) disable iff (rst)
        ref_req |-> !req_ack);

    // R11
    grant_idle_chk: assert property (@(posedge clk) disable iff (rst)
        ref_gnt |-> sd_cs_n);

endmodule

bind sdr_access_seq sdr_access_seq_chk #(
    .SA_W   (SA_W),
    .BE_W   (BE_W),
    .AP_BIT (AP_BIT)
) u_chk (
    .clk      (clk),
    .rst      (rst),
    .req_ack  (req_ack),
    .ref_req  (ref_req),
    .ref_gnt  (ref_gnt),
    .done     (done),
    .sd_cs_n  (sd_cs_n),
    .sd_ras_n (sd_ras_n),
    .sd_cas_n (sd_cas_n),
    .sd_we_n  (sd_we_n),
    .sd_a     (sd_a),
    .sd_dqm   (sd_dqm),
    .sd_dq_oe (sd_dq_oe)
);

// File: tb/tb_sdr_access_seq.sv
module tb_sdr_access_seq;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [1:0]  cfg_rcd = 2'd2, cfg_cas = 2'd1, cfg_wrec = 2'd2, cfg_pre = 2'd1;
    logic        req = 1'b0, req_we = 1'b0;
    logic [25:0] req_addr = '0;
    logic [31:0] req_wdata = '0;
    logic [3:0]  req_be = '0;
    logic        req_ack, done, ref_gnt;
    logic [31:0] rd_data;
    logic        ref_req = 1'b0;
    logic        sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n;
    logic [12:0] sd_a;
    logic [1:0]  sd_ba;
    logic [3:0]  sd_dqm;
    logic [31:0] sd_dq_out;
    logic        sd_dq_oe;
    logic [31:0] sd_dq_in = '0;

    int n_chk  = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    sdr_access_seq dut (
        .clk(clk), .rst(rst),
        .cfg_rcd(cfg_rcd), .cfg_cas(cfg_cas), .cfg_wrec(cfg_wrec), .cfg_pre(cfg_pre),
        .req(req), .req_we(req_we), .req_addr(req_addr), .req_wdata(req_wdata),
        .req_be(req_be), .req_ack(req_ack), .done(done), .rd_data(rd_data),
        .ref_req(ref_req), .ref_gnt(ref_gnt),
        .sd_cs_n(sd_cs_n), .sd_ras_n(sd_ras_n), .sd_cas_n(sd_cas_n), .sd_we_n(sd_we_n),
        .sd_a(sd_a), .sd_ba(sd_ba), .sd_dqm(sd_dqm),
        .sd_dq_out(sd_dq_out), .sd_dq_oe(sd_dq_oe), .sd_dq_in(sd_dq_in)
    );

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic t_reset();
        rst = 1'b1;
        repeat (3) @(negedge clk);
        #1;
        chk(sd_cs_n == 1'b1 && sd_dq_oe == 1'b0, "R1 pins in reset", {sd_cs_n, sd_dq_oe}, 2'b10);
        chk(sd_dqm == 4'hF, "R1 masks in reset", sd_dqm, 4'hF);
        @(negedge clk);
        rst = 1'b0;
        #1;
        chk(sd_cs_n == 1'b1 && sd_dq_oe == 1'b0, "R1 pins after reset", {sd_cs_n, sd_dq_oe}, 2'b10);
        chk(done == 1'b0 && req_ack == 1'b0 && ref_gnt == 1'b0, "R1 host side after reset",
            {done, req_ack, ref_gnt}, 3'b000);
    endtask

    // one complete access; pre_ref cycles of refresh contention before acceptance
    task automatic run_access(input string tag, input bit we, input logic [25:0] addr,
                              input logic [31:0] wd, input logic [3:0] be, input logic [31:0] rdv,
                              input logic [1:0] trcd, input logic [1:0] clc, input logic [1:0] twr,
                              input logic [1:0] trp, input int pre_ref);
        int len, cmd_k, cap_k, done_k;
        logic [12:0] exp_row, exp_col;
        logic [3:0]  exp_dqm;
        cfg_rcd = trcd; cfg_cas = clc; cfg_wrec = twr; cfg_pre = trp;
        cmd_k   = 1 + int'(trcd);
        cap_k   = cmd_k + 1 + int'(clc);
        done_k  = we ? cmd_k + 1 : cap_k + 1;
        len     = we ? 2 + int'(trcd) + int'(twr) + int'(trp)
                     : 4 + int'(trcd) + int'(clc) + int'(trp);
        exp_row = addr[23:11];
        exp_col = {2'b00, 1'b1, 1'b0, addr[10:2]};

        @(negedge clk);
        req = 1'b1; req_we = we; req_addr = addr; req_wdata = wd; req_be = be;
        for (int i = 0; i < pre_ref; i++) begin
            ref_req = 1'b1;
            #1;
            chk(ref_gnt == 1'b1 && req_ack == 1'b0, "R11 refresh beats host", {ref_gnt, req_ack}, 2'b10);
            chk(sd_cs_n == 1'b1, "R11 bus quiet while granted", sd_cs_n, 1'b1);
            @(negedge clk);
        end
        ref_req = 1'b0;
        #1;
        chk(req_ack == 1'b1, "R10 accept in idle", req_ack, 1'b1);
        @(negedge clk);
        // change every request input while busy and contend with refresh
        req_addr = ~addr; req_wdata = ~wd; req_be = ~be; req_we = ~we; ref_req = 1'b1;
        for (int k = 0; k <= len; k++) begin
            sd_dq_in = (!we && k == cap_k) ? rdv : ~rdv;
            #1;
            if (k == 0) begin
                chk({sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} == 4'b0011, tag,
                    {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n}, 4'b0011);
                chk(sd_a == exp_row && sd_ba == addr[25:24], "R5 row phase", {sd_ba, sd_a}, {addr[25:24], exp_row});
            end else if (k == cmd_k) begin
                chk({sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} == (we ? 4'b0100 : 4'b0101), tag,
                    {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n}, we ? 4'b0100 : 4'b0101);
                chk(sd_a == exp_col && sd_ba == addr[25:24], "R6 column phase", {sd_ba, sd_a}, {addr[25:24], exp_col});
            end else begin
                chk(sd_cs_n == 1'b1, tag, sd_cs_n, 1'b1);
            end
            exp_dqm = (we && k == cmd_k) ? ~be : 4'hF;
            chk(sd_dqm == exp_dqm, "R7 byte masks", sd_dqm, exp_dqm);
            chk(sd_dq_oe == (we && k == cmd_k), "R8 drive enable", sd_dq_oe, (we && k == cmd_k));
            if (we && k == cmd_k) chk(sd_dq_out == wd, "R8 write data", sd_dq_out, wd);
            chk(done == (k == done_k), "R9 done pulse", done, (k == done_k));
            if (!we && k == done_k) chk(rd_data == rdv, "R9 read data", rd_data, rdv);
            chk(req_ack == 1'b0, "R10 no accept while busy", req_ack, 1'b0);
            chk(ref_gnt == (k == len), "R11 grant only when idle", ref_gnt, (k == len));
            if (k < len) @(negedge clk);
        end
        req = 1'b0; ref_req = 1'b0;
    endtask

    task automatic t_read_reference();
        run_access("R2/R4 read 2-2-1", 1'b0, 26'h2A5_C3F4, 32'h0, 4'h0, 32'hCAFE_F00D,
                   2'd2, 2'd1, 2'd2, 2'd1, 0);
    endtask

    task automatic t_read_shortest();
        run_access("R2/R4 read no waits", 1'b0, 26'h1FF_FFFC, 32'h0, 4'h0, 32'h1234_5678,
                   2'd0, 2'd0, 2'd0, 2'd0, 0);
    endtask

    task automatic t_read_longest();
        run_access("R2/R4 read max waits", 1'b0, 26'h100_0404, 32'h0, 4'h0, 32'h8000_0001,
                   2'd3, 2'd3, 2'd3, 2'd3, 0);
    endtask

    task automatic t_write_reference();
        run_access("R3/R4 write 2-2-1", 1'b1, 26'h0C0_0818, 32'hA5A5_5A5A, 4'b0101, 32'h0,
                   2'd2, 2'd1, 2'd2, 2'd1, 0);
    endtask

    task automatic t_write_shortest();
        run_access("R3/R4 write no waits", 1'b1, 26'h3FF_F7FC, 32'h0BAD_BEEF, 4'b1000, 32'h0,
                   2'd0, 2'd2, 2'd0, 2'd0, 0);
    endtask

    task automatic t_refresh_collision();
        run_access("R2 read after refresh", 1'b0, 26'h055_0008, 32'h0, 4'h0, 32'h0F0F_F0F0,
                   2'd1, 2'd2, 2'd1, 2'd2, 3);
        run_access("R3 write after refresh", 1'b1, 26'h2AA_3FFC, 32'hFFFF_0000, 4'b1111, 32'h0,
                   2'd1, 2'd0, 2'd3, 2'd1, 1);
    endtask

    // four single reads forming one 16-byte transfer
    task automatic t_back_to_back();
        for (int b = 0; b < 4; b++) begin
            run_access("R2 consecutive beat", 1'b0, 26'h1A0_0100 + 26'(b * 4), 32'h0, 4'h0,
                       32'h5000_0000 + 32'(b), 2'd2, 2'd1, 2'd2, 2'd1, 0);
        end
    endtask

    initial begin
        t_reset();
        t_read_reference();
        t_read_shortest();
        t_read_longest();
        t_write_reference();
        t_write_shortest();
        t_refresh_collision();
        t_back_to_back();
        repeat (2) @(negedge clk);
        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        #(20 * 50000);
        if (!finished) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual running expected finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

endmodule